// File: doc/BRIEF.md
# Character Attribute Pixel Mixer

This block sits between the glyph fetch stage of an on-screen display and the video level encoder. For each display dot it takes the glyph bit of the current character, the bits of the dots around it, the character code, and the two per-character attributes. From these, and from a set of global display-control fields, it works out which kind of level the encoder should drive for that dot. The possible kinds are a character level, a blanking level, a background level, or transparent pass-through of the incoming picture.

The block handles reverse video and the highlight-or-flash attribute. The flash timing comes from a counter of field-start pulses, with a short or a long half period. It also handles four blanking area modes, the global display enable, and the choice of intensity index within each level kind. The result is registered once, so the code for a dot appears one clock after that dot's inputs.

Top module: `osd_dot_mixer`

## Requirements
- R1: `pix_code` is `{kind[1:0], idx[1:0]}`, registered one clock after its inputs. The kinds are 3 = character, 2 = blanking, 1 = background and 0 = transparent, and they take priority in that order. A character has idx `{0, char_lvl}`, blanking has idx `{0, blank_lvl}`, background has idx `bg_lvl`, and transparent is `4'b0000`.
- R2: A dot shows as a character dot only when `win_active` and `cell_active` are both high. With `attr_rev` high, the glyph bit is inverted before it is shown.
- R3: With `attr_flash` high and `flash_mode` = 1, the character dots of that cell are suppressed during the hidden half of the flash cycle. After reset the cycle starts in the visible half. Cells without `attr_flash` are never suppressed.
- R4: The flash phase toggles on the field-start pulse that completes a half period. A half period is 15 pulses when `flash_slow` = 0 and 30 pulses when `flash_slow` = 1. The phase changes at no other time.
- R5: With `attr_flash` high and `flash_mode` = 0 (highlight), character dots are never suppressed, and their idx bit is the inverse of `char_lvl`.
- R6: `blank_mode` selects the blanking area. 00 gives none. 01 covers the unlit dots of an active cell. 10 covers the unlit dots of a visible, non-reversed active cell that have at least one lit neighbour bit. 11 covers every unlit dot inside the window.
- R7: With `disp_on` low, neither character dots nor blanking are produced. Background and transparent output still follow R1.
- R8: A cell whose code is all ones (0xFF) counts as an empty cell. It shows no character dots even when reversed, and it gets neither character-size nor frame blanking. Whole-area blanking still covers it.
- R9: Outside the window (`win_active` low), the code is background when `bg_on` is high and transparent otherwise.
- R10: While `rst_n` is low, `pix_code` is `4'b0000`, the flash phase is visible and the field count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start | input | 1 | One-cycle pulse at the start of each field |
| win_active | input | 1 | Dot lies inside the display window |
| cell_active | input | 1 | Dot lies inside a character cell |
| glyph_dot | input | 1 | Glyph bit of the current dot |
| glyph_nbr | input | NBR_N (8) | Glyph bits of the neighbouring dots |
| char_code | input | CODE_W (8) | Character code of the current cell |
| attr_rev | input | 1 | Per-character reverse attribute |
| attr_flash | input | 1 | Per-character highlight/flash attribute |
| disp_on | input | 1 | Global display enable |
| flash_mode | input | 1 | 0 = highlight, 1 = flash |
| flash_slow | input | 1 | 0 = short flash period, 1 = long flash period |
| blank_mode | input | 2 | Blanking area mode |
| char_lvl | input | 1 | Character intensity select |
| blank_lvl | input | 1 | Blanking intensity select |
| bg_on | input | 1 | Background enable |
| bg_lvl | input | 2 | Background intensity select |
| pix_code | output | 4 | Registered level code |

## Verification
Most faults in this block's state show up as a wrong kind field on the very next clock. A wrong flash phase turns lit flashing dots transparent, or leaves them lit, from the dot after the offending field pulse. A field counter that is off by one shows as a phase flip one field early or late, so the bench counts pulses exactly on both sides of each boundary. A blanking or priority error changes the kind of an unlit dot in the next cycle. Each blanking mode is therefore probed with dots inside and outside the cell and with and without lit neighbours.

// File: rtl/osd_mix_pkg.sv
package osd_mix_pkg;

   typedef enum logic [1:0] {
      LK_TRANSP = 2'd0,
      LK_BG     = 2'd1,
      LK_BLANK  = 2'd2,
      LK_CHAR   = 2'd3
   } lvl_kind_e;

   typedef enum logic [1:0] {
      BM_NONE  = 2'd0,
      BM_CELL  = 2'd1,
      BM_FRAME = 2'd2,
      BM_ALL   = 2'd3
   } blank_mode_e;

   typedef struct packed {
      lvl_kind_e  kind;
      logic [1:0] idx;
   } lvl_code_t;

   localparam int LVL_CODE_W = $bits(lvl_code_t);

endpackage

// File: rtl/osd_flash_timer.sv
module osd_flash_timer #(
   parameter int FLD_SHORT = 15,
   parameter int FLD_LONG  = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic field_start,
   input  logic slow,
   output logic hidden
);
   localparam int CNT_W = $clog2(FLD_LONG + 1);
   localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(FLD_SHORT - 1);
   localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(FLD_LONG - 1);

   logic [CNT_W-1:0] fld_cnt;
   logic [CNT_W-1:0] last_cnt;

   assign last_cnt = slow ? LAST_LONG : LAST_SHORT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fld_cnt <= '0;
         hidden  <= 1'b0;
      end else if (field_start) begin
         if (fld_cnt >= last_cnt) begin
            fld_cnt <= '0;
            hidden  <= ~hidden;
         end else begin
            fld_cnt <= fld_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/osd_frame_detect.sv
module osd_frame_detect #(
   parameter int          NBR_N    = 8,
   parameter logic [NBR_N-1:0] NBR_MASK = '1
) (
   input  logic [NBR_N-1:0] nbr,
   output logic             edge_hit
);
   logic [NBR_N-1:0] hit;

   for (genvar i = 0; i < NBR_N; i++) begin : g_nbr
      if (NBR_MASK[i]) begin : g_use
         assign hit[i] = nbr[i];
      end else begin : g_skip
         assign hit[i] = 1'b0;
      end
   end

   assign edge_hit = |hit;
endmodule

// File: rtl/osd_level_pick.sv
module osd_level_pick
   import osd_mix_pkg::*;
(
   input  logic       lit,
   input  logic       lit_alt,
   input  logic       blank_hit,
   input  logic       bg_on,
   input  logic       char_lvl,
   input  logic       blank_lvl,
   input  logic [1:0] bg_lvl,
   output lvl_code_t  code
);
   always_comb begin
      if (lit) begin
         code.kind = LK_CHAR;
         code.idx  = {1'b0, char_lvl ^ lit_alt};
      end else if (blank_hit) begin
         code.kind = LK_BLANK;
         code.idx  = {1'b0, blank_lvl};
      end else if (bg_on) begin
         code.kind = LK_BG;
         code.idx  = bg_lvl;
      end else begin
         code.kind = LK_TRANSP;
         code.idx  = 2'b00;
      end
   end
endmodule

// File: rtl/osd_dot_mixer.sv
module osd_dot_mixer
   import osd_mix_pkg::*;
#(
   parameter int               CODE_W    = 8,
   parameter int               NBR_N     = 8,
   parameter logic [NBR_N-1:0] NBR_MASK  = '1,
   parameter int               FLD_SHORT = 15,
   parameter int               FLD_LONG  = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              field_start,
   input  logic              win_active,
   input  logic              cell_active,
   input  logic              glyph_dot,
   input  logic [NBR_N-1:0]  glyph_nbr,
   input  logic [CODE_W-1:0] char_code,
   input  logic              attr_rev,
   input  logic              attr_flash,
   input  logic              disp_on,
   input  logic              flash_mode,
   input  logic              flash_slow,
   input  logic [1:0]        blank_mode,
   input  logic              char_lvl,
   input  logic              blank_lvl,
   input  logic              bg_on,
   input  logic [1:0]        bg_lvl,
   output logic [3:0]        pix_code
);
   localparam logic [CODE_W-1:0] EMPTY_CODE = '1;

   if (FLD_SHORT < 1 || FLD_LONG <= FLD_SHORT) begin : g_bad_fld
      $error("flash field counts must satisfy 1 <= FLD_SHORT < FLD_LONG");
   end
   if (NBR_N != 4 && NBR_N != 8) begin : g_bad_nbr
      $error("NBR_N must be 4 or 8");
   end
   if (LVL_CODE_W != 4) begin : g_bad_code
      $error("level code must be four bits wide");
   end

   logic        flash_hidden;
   logic        nbr_hit;
   logic        cell_eff;
   logic        show;
   logic        lit;
   logic        in_win;
   logic        blank_hit;
   blank_mode_e bmode;
   lvl_code_t   next_code;
   lvl_code_t   code_q;

   osd_flash_timer #(
      .FLD_SHORT (FLD_SHORT),
      .FLD_LONG  (FLD_LONG)
   ) u_flash (
      .clk         (clk),
      .rst_n       (rst_n),
      .field_start (field_start),
      .slow        (flash_slow),
      .hidden      (flash_hidden)
   );

   osd_frame_detect #(
      .NBR_N    (NBR_N),
      .NBR_MASK (NBR_MASK)
   ) u_frame (
      .nbr      (glyph_nbr),
      .edge_hit (nbr_hit)
   );

   assign bmode    = blank_mode_e'(blank_mode);
   assign in_win   = win_active & disp_on;
   assign cell_eff = in_win & cell_active & (char_code != EMPTY_CODE);
   assign show     = cell_eff & ~(attr_flash & flash_mode & flash_hidden);
   assign lit      = show & (glyph_dot ^ attr_rev);

   always_comb begin
      unique case (bmode)
         BM_NONE:  blank_hit = 1'b0;
         BM_CELL:  blank_hit = cell_eff;
         BM_FRAME: blank_hit = show & ~attr_rev & nbr_hit;
         BM_ALL:   blank_hit = in_win;
      endcase
   end

   osd_level_pick u_pick (
      .lit       (lit),
      .lit_alt   (attr_flash & ~flash_mode),
      .blank_hit (blank_hit),
      .bg_on     (bg_on),
      .char_lvl  (char_lvl),
      .blank_lvl (blank_lvl),
      .bg_lvl    (bg_lvl),
      .code      (next_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= '{kind: LK_TRANSP, idx: 2'b00};
      else        code_q <= next_code;
   end

   assign pix_code = code_q;
endmodule

// File: rtl/osd_dot_mixer_chk.sv
module osd_dot_mixer_chk #(
   parameter int CODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              field_start,
   input logic              win_active,
   input logic [CODE_W-1:0] char_code,
   input logic              attr_flash,
   input logic              disp_on,
   input logic              flash_mode,
   input logic              bg_on,
   input logic [1:0]        bg_lvl,
   input logic              flash_hidden,
   input logic [3:0]        pix_code
);
   // R10: reset holds the output at transparent
   always @(negedge clk) begin
      if (!rst_n) p_reset_idle_r10: assert (pix_code == 4'b0000);
   end

   p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_on |=> !pix_code[3]);

   p_outside_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_active && bg_on) |=> pix_code == {2'b01, $past(bg_lvl)});

   p_empty_cell_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (char_code == '1) |=> pix_code[3:2] != 2'b11);

   p_flash_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (attr_flash && flash_mode && flash_hidden) |=> pix_code[3:2] != 2'b11);

   p_phase_on_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(flash_hidden) |-> $past(field_start));
endmodule

bind osd_dot_mixer osd_dot_mixer_chk #(.CODE_W(CODE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .field_start  (field_start),
   .win_active   (win_active),
   .char_code    (char_code),
   .attr_flash   (attr_flash),
   .disp_on      (disp_on),
   .flash_mode   (flash_mode),
   .bg_on        (bg_on),
   .bg_lvl       (bg_lvl),
   .flash_hidden (flash_hidden),
   .pix_code     (pix_code)
);

// File: tb/osd_dot_mixer_bench.sv
module osd_dot_mixer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       field_start = 1'b0;
   logic       win_active = 1'b0, cell_active = 1'b0, glyph_dot = 1'b0;
   logic [7:0] glyph_nbr = '0, char_code = 8'h41;
   logic       attr_rev = 1'b0, attr_flash = 1'b0, disp_on = 1'b0;
   logic       flash_mode = 1'b0, flash_slow = 1'b0;
   logic [1:0] blank_mode = 2'b00;
   logic       char_lvl = 1'b0, blank_lvl = 1'b0, bg_on = 1'b0;
   logic [1:0] bg_lvl = 2'b00;
   logic [3:0] pix_code;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   osd_dot_mixer u_osd_dot_mixer (.*);

   // tag, win, cell, dot, nbr, rev, flash, empty, on, fmode, bmode, clvl, blvl, bgon, bglvl, expect
   function automatic logic [30:0] vec(input logic [3:0] t, input logic w, c, d,
      input logic [7:0] n, input logic r, f, e, o, fm, input logic [1:0] bm,
      input logic cl, bl, bo, input logic [1:0] bg, input logic [3:0] x);
      return {t, w, c, d, n, r, f, e, o, fm, bm, cl, bl, bo, bg, x};
   endfunction

   localparam int NV = 21;
   localparam logic [30:0] VT [NV] = '{
      vec(1, 1,1,1, 8'h00, 0,0,0,1,0, 2'd0, 0,0,0, 2'd0, 4'b1100), // R1 lit dot
      vec(1, 1,1,1, 8'h00, 0,0,0,1,0, 2'd0, 1,0,0, 2'd0, 4'b1101), // R1 char level B
      vec(1, 1,1,0, 8'h00, 0,0,0,1,0, 2'd0, 0,0,1, 2'd2, 4'b0110), // R1 background
      vec(1, 1,1,0, 8'h00, 0,0,0,1,0, 2'd0, 0,0,0, 2'd0, 4'b0000), // R1 transparent
      vec(2, 1,1,0, 8'h00, 1,0,0,1,0, 2'd0, 0,0,0, 2'd0, 4'b1100), // R2 reverse fills
      vec(2, 1,1,1, 8'h00, 1,0,0,1,0, 2'd0, 0,0,0, 2'd0, 4'b0000), // R2 reverse clears
      vec(5, 1,1,1, 8'h00, 0,1,0,1,0, 2'd0, 0,0,0, 2'd0, 4'b1101), // R5 highlight
      vec(3, 1,1,1, 8'h00, 0,1,0,1,1, 2'd0, 0,0,0, 2'd0, 4'b1100), // R3 visible phase
      vec(6, 1,1,0, 8'h00, 0,0,0,1,0, 2'd1, 0,1,0, 2'd0, 4'b1001), // R6 cell blank
      vec(6, 1,0,0, 8'h00, 0,0,0,1,0, 2'd1, 0,0,1, 2'd3, 4'b0111), // R6 cell blank off-cell
      vec(6, 1,1,0, 8'h10, 0,0,0,1,0, 2'd2, 0,0,0, 2'd0, 4'b1000), // R6 frame edge
      vec(6, 1,1,0, 8'h00, 0,0,0,1,0, 2'd2, 0,0,0, 2'd0, 4'b0000), // R6 frame no neighbour
      vec(6, 1,1,1, 8'hFF, 1,0,0,1,0, 2'd2, 0,0,0, 2'd0, 4'b0000), // R6 frame not on reversed
      vec(6, 1,0,0, 8'h00, 0,0,0,1,0, 2'd3, 0,0,0, 2'd0, 4'b1000), // R6 whole area
      vec(6, 1,1,1, 8'h00, 0,0,0,1,0, 2'd3, 0,0,0, 2'd0, 4'b1100), // R6 char over whole area
      vec(7, 1,1,1, 8'h00, 0,0,0,0,0, 2'd3, 0,0,1, 2'd1, 4'b0101), // R7 display off
      vec(8, 1,1,1, 8'hFF, 1,0,1,1,0, 2'd2, 0,0,0, 2'd0, 4'b0000), // R8 empty reversed
      vec(8, 1,1,0, 8'h00, 0,0,1,1,0, 2'd1, 0,0,0, 2'd0, 4'b0000), // R8 empty no cell blank
      vec(8, 1,1,0, 8'h00, 0,0,1,1,0, 2'd3, 0,0,0, 2'd0, 4'b1000), // R8 empty whole area
      vec(9, 0,1,1, 8'h00, 0,0,0,1,0, 2'd3, 0,0,1, 2'd0, 4'b0100), // R9 outside, background
      vec(9, 0,1,1, 8'h00, 0,0,0,1,0, 2'd3, 0,0,0, 2'd0, 4'b0000)  // R9 outside, transparent
   };

   task automatic check(input string req, input logic [3:0] exp);
      checks++;
      if (pix_code !== exp) begin
         errors++;
         $display("FAIL %s actual %b expected %b", req, pix_code, exp);
      end
   endtask

   task automatic pulse_fields(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) field_start = 1'b1;
         @(negedge clk) field_start = 1'b0;
      end
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      win_active = 1'b1; cell_active = 1'b1; glyph_dot = 1'b1; disp_on = 1'b1;
      bg_on = 1'b1; bg_lvl = 2'd3;
      repeat (3) @(negedge clk);
      check("R10 reset output", 4'b0000);
      rst_n = 1'b1;
      bg_on = 1'b0;

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         win_active  = VT[k][26]; cell_active = VT[k][25]; glyph_dot = VT[k][24];
         glyph_nbr   = VT[k][23:16]; attr_rev = VT[k][15]; attr_flash = VT[k][14];
         char_code   = VT[k][13] ? 8'hFF : 8'h41; disp_on = VT[k][12];
         flash_mode  = VT[k][11]; blank_mode = VT[k][10:9]; char_lvl = VT[k][8];
         blank_lvl   = VT[k][7]; bg_on = VT[k][6]; bg_lvl = VT[k][5:4];
         @(negedge clk);
         check($sformatf("R%0d row %0d", VT[k][30:27], k), VT[k][3:0]);
      end

      // flash timing, R3 and R4
      win_active = 1; cell_active = 1; glyph_dot = 1; glyph_nbr = '0; attr_rev = 0;
      char_code = 8'h41; disp_on = 1; blank_mode = 2'd0; char_lvl = 0; bg_on = 0;
      attr_flash = 1; flash_mode = 1; flash_slow = 0;
      pulse_fields(14);
      check("R4 short period, 14 fields still visible", 4'b1100);
      pulse_fields(1);
      check("R3 hidden after 15 fields", 4'b0000);
      attr_flash = 0;
      @(negedge clk);
      check("R3 plain cell not hidden", 4'b1100);
      attr_flash = 1; flash_mode = 0;
      @(negedge clk);
      check("R5 highlight ignores flash phase", 4'b1101);
      flash_mode = 1;
      pulse_fields(14);
      check("R4 still hidden at 29 fields", 4'b0000);
      pulse_fields(1);
      check("R4 visible after second half period", 4'b1100);
      flash_slow = 1;
      pulse_fields(29);
      check("R4 long period, 29 fields visible", 4'b1100);
      pulse_fields(1);
      check("R4 long period, hidden at 30", 4'b0000);

      // R10 reset restores visible phase
      rst_n = 0;
      @(negedge clk);
      check("R10 output cleared in reset", 4'b0000);
      rst_n = 1;
      @(negedge clk);
      @(negedge clk);
      check("R10 phase visible after reset", 4'b1100);

      finish_run();
   end
endmodule